// File: doc/BRIEF.md
# Sector Receive Buffer Read Port

This block holds the most recently decoded disc sector and hands it to the host. A load side writes bytes into a byte-addressed store and then, with a single commit strobe, declares how many of them are valid. The valid count is fixed by the sector format: the long form (the whole sector without its 12-byte sync field) or the short form (the 2048-byte user payload).

The host reads the store through a cursor. A run bit, set through a control write, enables reading. While the run bit is set, every byte taken advances the cursor. The run bit drops by itself when the cursor reaches the valid count. Reads made while the run bit is clear return the byte under the cursor and leave the cursor where it is. A DMA engine may take four bytes per request, packed little-endian. Dropping the run bit through a control write snaps the cursor to an 8-byte boundary, rounding to the nearest boundary with the half-way point going upward.

A free-running sector timer sits alongside the store. It raises a one-cycle tick once per sector period. The period is set by the drive speed.

Top module: `sector_rx_buffer`

## Requirements
- R1: After reset the run bit is 0, the cursor is 0, the valid count is 0, data_avail is 0 and sector_tick is 0.
- R2: A control write with ctrl_run=1 while the run bit is 0 sets the run bit and moves the cursor to 0. The same write while the run bit is already 1 leaves the cursor unchanged.
- R3: A control write with ctrl_run=0 clears the run bit and sets the cursor to (cursor with bits 2:0 cleared) plus 8 when cursor bit 2 was 1.
- R4: A byte read while the run bit is 1 presents the stored byte at the cursor on byte_data one cycle later and advances the cursor by one. When the advanced cursor equals the valid count, the run bit clears.
- R5: A byte read while the run bit is 0 presents the stored byte at the cursor and leaves the cursor unchanged.
- R6: A word read behaves as four byte reads in sequence. The first byte lands in word_data bits 7:0, the second in bits 15:8, the third in 23:16 and the fourth in 31:24. If the run bit clears part-way through the word, the remaining bytes repeat the byte at the stopped cursor.
- R7: wr_en stores wr_data at wr_addr. sector_done sets the valid count to WHOLE_LEN (default 0x924) when whole_sector=1, and to PART_LEN (default 0x800) when whole_sector=0. The cursor is not changed.
- R8: data_avail is 1 exactly while the cursor is below the valid count.
- R9: While tick_en is 1, sector_tick pulses high for one cycle every PERIOD_1X cycles when speed_2x=0, and every PERIOD_1X/2 cycles when speed_2x=1. The first pulse comes that many cycles after tick_en rises. While tick_en is 0, no pulse occurs and the timer reloads.
- R10: A control write takes priority over a read in the same cycle: the cursor and run bit follow R2/R3 only. A word read takes priority over a byte read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store one byte from the load side |
| wr_addr | input | AW | Store address |
| wr_data | input | 8 | Store data |
| sector_done | input | 1 | Commit: set the valid count |
| whole_sector | input | 1 | Selects the long (1) or short (0) valid count at commit |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_run | input | 1 | Run bit value for the control write |
| byte_rd | input | 1 | Single-byte read request |
| word_rd | input | 1 | Four-byte DMA read request |
| byte_data | output | 8 | Byte returned by the last byte read |
| word_data | output | 32 | Little-endian word returned by the last word read |
| rx_active | output | 1 | Run bit |
| rx_index | output | IW | Read cursor |
| data_avail | output | 1 | Cursor below valid count |
| speed_2x | input | 1 | Double-speed period select |
| tick_en | input | 1 | Sector timer enable |
| sector_tick | output | 1 | One-cycle sector-ready pulse |

## Verification
The bench stops the cursor after every count from 0 to 39 and checks the snap result. A design that truncated instead of rounding, or that rounded at the wrong bit, would leave the cursor eight bytes off for half of these stopping points. Word reads are made across the end of the valid region, both exactly at a word boundary and two bytes short of it. A design that kept advancing past the end, or packed bytes big-endian, would show a wrong cursor or scrambled lanes. Tick spacing is measured at both speeds, from enable to first tick and between ticks, so an off-by-one reload would show as a period one cycle long or short.

// File: rtl/sector_rx_buffer.sv
module sector_rx_buffer #(
  parameter int DEPTH     = 2352,
  parameter int WHOLE_LEN = 2340,
  parameter int PART_LEN  = 2048,
  parameter int PERIOD_1X = 451584,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(DEPTH + 8) + 1,
  localparam int PW = $clog2(PERIOD_1X + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          sector_done,
  input  logic          whole_sector,
  input  logic          ctrl_wr,
  input  logic          ctrl_run,
  input  logic          byte_rd,
  input  logic          word_rd,
  output logic [7:0]    byte_data,
  output logic [31:0]   word_data,
  output logic          rx_active,
  output logic [IW-1:0] rx_index,
  output logic          data_avail,
  input  logic          speed_2x,
  input  logic          tick_en,
  output logic          sector_tick
);

  logic [7:0]    store [2**AW];
  logic [IW-1:0] idx_q, len_q;
  logic          act_q;

  always_ff @(posedge clk)
    if (wr_en) store[wr_addr] <= wr_data;

  logic [IW-1:0] byte_idx;
  logic          byte_act;
  assign byte_idx = act_q ? idx_q + 1'b1 : idx_q;
  assign byte_act = act_q && ((idx_q + 1'b1) != len_q);

  logic [IW-1:0] word_idx;
  logic          word_act;
  logic [31:0]   word_bytes;

  always_comb begin
    logic [IW-1:0] i;
    logic          a;
    i = idx_q;
    a = act_q;
    word_bytes = '0;
    for (int k = 0; k < 4; k++) begin
      word_bytes[8*k +: 8] = store[i[AW-1:0]];
      if (a) begin
        i = i + 1'b1;
        a = (i != len_q);
      end
    end
    word_idx = i;
    word_act = a;
  end

  logic [IW-1:0] snap_idx;
  assign snap_idx = {idx_q[IW-1:3], 3'b000} + (idx_q[2] ? IW'(8) : IW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      act_q     <= 1'b0;
      len_q     <= '0;
      byte_data <= '0;
      word_data <= '0;
    end else begin
      if (sector_done)
        len_q <= whole_sector ? IW'(WHOLE_LEN) : IW'(PART_LEN);
      if (word_rd)
        word_data <= word_bytes;
      else if (byte_rd)
        byte_data <= store[idx_q[AW-1:0]];
      if (ctrl_wr) begin
        act_q <= ctrl_run;
        if (ctrl_run && !act_q) idx_q <= '0;
        else if (!ctrl_run)     idx_q <= snap_idx;
      end else if (word_rd) begin
        idx_q <= word_idx;
        act_q <= word_act;
      end else if (byte_rd) begin
        idx_q <= byte_idx;
        act_q <= byte_act;
      end
    end
  end

  assign rx_active  = act_q;
  assign rx_index   = idx_q;
  assign data_avail = idx_q < len_q;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] reload;
  assign reload = speed_2x ? PW'(PERIOD_1X / 2 - 1) : PW'(PERIOD_1X - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      sector_tick <= 1'b0;
    end else if (!tick_en) begin
      cnt_q       <= reload;
      sector_tick <= 1'b0;
    end else begin
      sector_tick <= (cnt_q == '0);
      cnt_q       <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sector_rx_buffer_chk.sv
module sector_rx_buffer_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          ctrl_run,
  input logic          byte_rd,
  input logic          word_rd,
  input logic          rx_active,
  input logic [IW-1:0] rx_index,
  input logic [IW-1:0] len_q,
  input logic          sector_tick
);

  AST_RUN_RISE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_run && !rx_active |=> rx_index == '0); // R2

  AST_SNAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !ctrl_run |=> rx_index[2:0] == 3'b000 && !rx_active); // R3

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd && !word_rd && !ctrl_wr && rx_active |=> rx_index == $past(rx_index) + 1'b1); // R4

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd && !word_rd && !ctrl_wr && rx_active && (rx_index + 1'b1) == len_q |=> !rx_active); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd || word_rd) && !ctrl_wr && !rx_active |=> $stable(rx_index) && !rx_active); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sector_tick |=> !sector_tick); // R9

endmodule

bind sector_rx_buffer sector_rx_buffer_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run),
  .byte_rd(byte_rd), .word_rd(word_rd), .rx_active(rx_active),
  .rx_index(rx_index), .len_q(len_q), .sector_tick(sector_tick)
);

// File: tb/tb_sector_rx_buffer.sv
`timescale 1ns/1ps
module tb_sector_rx_buffer;
  localparam int DEPTH = 64, WL = 40, PL = 32, P1 = 20;
  localparam int AW = 6, IW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sector_done = 0, whole_sector = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ctrl_wr = 0, ctrl_run = 0, byte_rd = 0, word_rd = 0;
  logic speed_2x = 0, tick_en = 0;
  logic [7:0] byte_data;
  logic [31:0] word_data;
  logic rx_active, data_avail, sector_tick;
  logic [IW-1:0] rx_index;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sector_rx_buffer #(.DEPTH(DEPTH), .WHOLE_LEN(WL), .PART_LEN(PL), .PERIOD_1X(P1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sector_done(sector_done), .whole_sector(whole_sector),
    .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run), .byte_rd(byte_rd), .word_rd(word_rd),
    .byte_data(byte_data), .word_data(word_data), .rx_active(rx_active),
    .rx_index(rx_index), .data_avail(data_avail),
    .speed_2x(speed_2x), .tick_en(tick_en), .sector_tick(sector_tick));

  function automatic int pat(int a);
    return (a * 37 + 5) & 255;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic ctrl(input bit run);
    @(negedge clk); ctrl_wr = 1; ctrl_run = run;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic rd_byte();
    @(negedge clk); byte_rd = 1;
    @(negedge clk); byte_rd = 0;
  endtask

  task automatic rd_word();
    @(negedge clk); word_rd = 1;
    @(negedge clk); word_rd = 0;
  endtask

  task automatic commit(input bit whole);
    @(negedge clk); sector_done = 1; whole_sector = whole;
    @(negedge clk); sector_done = 0;
  endtask

  function automatic longint wexp(int a, int b, int c, int d);
    return longint'(pat(a)) | (longint'(pat(b)) << 8) | (longint'(pat(c)) << 16) | (longint'(pat(d)) << 24);
  endfunction

  task automatic measure(input int p, input string req);
    int n;
    @(negedge clk); tick_en = 0;
    @(negedge clk); tick_en = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sector_tick && n < 4 * p);
    chk({req, " first tick latency"}, n, p);
    n = 0;
    do begin @(negedge clk); n++; end while (!sector_tick && n < 4 * p);
    chk({req, " tick interval"}, n, p);
    @(negedge clk);
    chk({req, " tick width one cycle"}, sector_tick, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", rx_active, 0);
    chk("R1 index", rx_index, 0);
    chk("R1 avail", data_avail, 0);
    chk("R1 tick", sector_tick, 0);
    rst_n = 1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = 8'(pat(a));
    end
    @(negedge clk); wr_en = 0;
    chk("R8 avail with zero length", data_avail, 0);
    // R7 long commit
    commit(1);
    chk("R7 R8 avail after long commit", data_avail, 1);
    // R2 activation and full byte sweep R4
    ctrl(1);
    chk("R2 index zero on activate", rx_index, 0);
    chk("R2 active", rx_active, 1);
    for (int i = 0; i < WL; i++) begin
      rd_byte();
      chk("R4 byte data", byte_data, pat(i));
      chk("R4 index step", rx_index, i + 1);
      chk("R4 active until end", rx_active, (i + 1) != WL);
      chk("R8 avail", data_avail, (i + 1) < WL);
    end
    // R5 inactive read
    rd_byte();
    chk("R5 idle byte data", byte_data, pat(WL));
    chk("R5 idle index hold", rx_index, WL);
    // R3 snap sweep
    for (int n = 0; n < WL; n++) begin
      ctrl(1);
      for (int k = 0; k < n; k++) rd_byte();
      chk("R3 pre-snap index", rx_index, n);
      ctrl(0);
      chk("R3 snapped index", rx_index, (n & ~7) + (((n & 4) != 0) ? 8 : 0));
      chk("R3 inactive after clear", rx_active, 0);
    end
    // R2 re-activation while active keeps cursor; R10 priority
    ctrl(1);
    rd_byte(); rd_byte(); rd_byte();
    ctrl(1);
    chk("R2 index kept when already active", rx_index, 3);
    @(negedge clk); ctrl_wr = 1; ctrl_run = 1; byte_rd = 1;
    @(negedge clk); ctrl_wr = 0; byte_rd = 0;
    chk("R10 control beats byte read", rx_index, 3);
    @(negedge clk); word_rd = 1; byte_rd = 1;
    @(negedge clk); word_rd = 0; byte_rd = 0;
    chk("R10 word beats byte", rx_index, 7);
    chk("R10 word data", word_data, wexp(3, 4, 5, 6));
    ctrl(0);
    chk("R3 snap of 7", rx_index, 8);
    // R6 words with mid-word stop
    ctrl(1);
    for (int w = 0; w < 9; w++) begin
      rd_word();
      chk("R6 word pack", word_data, wexp(4*w, 4*w+1, 4*w+2, 4*w+3));
    end
    rd_byte(); rd_byte();
    rd_word();
    chk("R6 word across end", word_data, wexp(38, 39, 40, 40));
    chk("R6 index stops at length", rx_index, WL);
    chk("R6 active cleared", rx_active, 0);
    rd_word();
    chk("R6 R5 idle word", word_data, wexp(40, 40, 40, 40));
    chk("R5 idle word index", rx_index, WL);
    // R7 short commit
    commit(0);
    chk("R7 R8 index above short length", data_avail, 0);
    chk("R7 index kept on commit", rx_index, WL);
    ctrl(1);
    for (int w = 0; w < PL / 4; w++) begin
      rd_word();
      chk("R6 short word", word_data, wexp(4*w, 4*w+1, 4*w+2, 4*w+3));
      chk("R7 active in short sector", rx_active, (w + 1) != PL / 4);
    end
    chk("R7 short end index", rx_index, PL);
    chk("R8 avail at end", data_avail, 0);
    ctrl(0);
    chk("R3 aligned index unchanged", rx_index, PL);
    // R9 sector timer
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R9 no tick while disabled", sector_tick, 0);
    end
    speed_2x = 0;
    measure(P1, "R9 1x");
    speed_2x = 1;
    measure(P1 / 2, "R9 2x");
    @(negedge clk); tick_en = 0;
    finish_run();
  end
endmodule